// File: doc/BRIEF.md
# Merging Write Buffer

This block sits between a write-through cache and the next memory level. The processor hands it single-word stores and moves on without waiting for memory. Stores that fall in the same aligned block of `WORDS` words are gathered into one buffer entry. Each word slot in the entry has its own valid bit, so four stores to consecutive words of one block take one entry instead of four. Entries leave the buffer for memory in the order they were allocated. Each entry goes out as a single transfer that carries the block address, every word and the per-word mask.

When the cache misses on a read, the miss logic gives the block address to the lookup port before it starts the memory read. If no buffered entry holds that block, the conflict output stays low and the read may start at once, ahead of the buffered writes. If the block is buffered, the conflict output stays high until every entry for that block has drained. This keeps a read from returning stale data.

The head entry is held back for a short while so that later stores can still merge into it. It starts draining as soon as it is full, as soon as another entry is queued behind it, or after `HOLD` cycles in which no store was accepted. After it starts draining it can no longer take merges.

Top module: `merge_wbuf`

## Requirements
- R1: After a synchronous active-low reset the buffer is empty: `cpu_wr_stall`, `mem_wr_valid` and `rd_conflict` are all 0.
- R2: `cpu_wr_addr` is a word address. Its low log2(WORDS) bits select the word slot, and the rest is the block address. A store accepted while an occupied entry holds the same block and is not being drained is merged into that entry and sets mask bit i for word i. Four stores to words 0..3 of one block produce one entry with mask 4'b1111.
- R3: A store to a word slot that is already valid in a mergeable entry replaces that word's data. No new entry is allocated.
- R4: A store with no mergeable entry takes the next free entry with only its own mask bit set. `cpu_wr_stall` is 1 exactly when a store is offered, no mergeable entry matches it and all ENTRIES entries are occupied. A merging store is accepted even when the buffer is full.
- R5: Entries drain in allocation order. `mem_wr_blk` is the entry's block address, `mem_wr_mask` bit i flags word i, and word i of the entry is at `mem_wr_data[i*DW +: DW]`. An entry is released on a cycle with `mem_wr_valid` and `mem_wr_ready` both 1.
- R6: The head entry is offered to memory when it is full, or when a second entry is occupied, or when HOLD (default 4) consecutive clock edges pass without an accepted store. Once `mem_wr_valid` is 1, it stays 1 with block, mask and data stable until `mem_wr_ready` is 1.
- R7: While the head entry is offered to memory (`mem_wr_valid` is 1), a store to its block does not merge into it. The store allocates a new entry instead.
- R8: `rd_conflict` is 1, in the same cycle, exactly when `rd_chk_blk` equals the block address of an occupied entry, including an entry that is being drained. Otherwise it is 0 and the read may proceed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_wr_valid | input | 1 | Processor offers a store |
| cpu_wr_addr | input | AW | Word address of the store |
| cpu_wr_data | input | DW | Store data |
| cpu_wr_stall | output | 1 | Store not accepted this cycle |
| rd_chk_blk | input | AW-log2(WORDS) | Block address of a pending read miss |
| rd_conflict | output | 1 | Read miss block is still buffered |
| mem_wr_valid | output | 1 | Head entry offered to memory |
| mem_wr_ready | input | 1 | Memory takes the offered entry |
| mem_wr_blk | output | AW-log2(WORDS) | Block address of offered entry |
| mem_wr_mask | output | WORDS | Valid word slots of offered entry |
| mem_wr_data | output | WORDS*DW | Word data of offered entry |

## Verification
`cpu_wr_stall` and `rd_conflict` are combinational on the stored state and the current inputs, so the bench reads them one time unit after it drives inputs on a falling edge. A store's effect on stored state and on `mem_wr_valid` is due one rising edge later, so the bench samples at the next falling edge. For the idle-based drain start, the bench counts HOLD rising edges from the last store and checks that `mem_wr_valid` is still low after HOLD-1 edges and high after HOLD. A released entry vanishes from the memory port and from the conflict lookup one edge after the `mem_wr_ready` handshake.

// File: rtl/wbm_pkg.sv
// Shared types for the merging write buffer.
package wbm_pkg;
    // Phase of the head entry: still gathering stores, or offered to memory.
    typedef enum logic {
        HD_GATHER = 1'b0,
        HD_SEND   = 1'b1
    } head_state_e;
endpackage

// File: rtl/wbm_tag_match.sv
// Compares one probe block address against every entry's stored block.
// Assumes entry tags are packed side by side, entry i at [i*TW +: TW].
// Entries flagged in excl are never reported as hits.
module wbm_tag_match #(
    parameter int ENTRIES = 4,
    parameter int TW      = 28
) (
    input  logic [ENTRIES-1:0]    occ,
    input  logic [ENTRIES-1:0]    excl,
    input  logic [ENTRIES*TW-1:0] tags_flat,
    input  logic [TW-1:0]         probe,
    output logic [ENTRIES-1:0]    hit
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        // Per-entry comparator gated by occupancy and exclusion.
        assign hit[i] = occ[i] && !excl[i] && (tags_flat[i*TW +: TW] == probe);
    end
endmodule

// File: rtl/wbm_prio.sv
// Picks the lowest set bit of a request vector and reports whether any is set.
// Assumes at most a few entries; a linear scan is short enough.
module wbm_prio #(
    parameter int N  = 4,
    localparam int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [PW-1:0] idx
);
    // Scan from the top so the lowest set bit wins.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = PW'(i);
        end
    end

    assign any = |req;
endmodule

// File: rtl/wbm_entry_store.sv
// Storage for the buffer entries: occupancy, block tag, per-word mask, data.
// Assumes the controller never allocates into an occupied slot and never
// merges into and allocates in the same cycle (one store per cycle).
module wbm_entry_store #(
    parameter int ENTRIES = 4,
    parameter int WORDS   = 4,
    parameter int DW      = 32,
    parameter int TW      = 28,
    localparam int PW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int WIDX   = $clog2(WORDS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_fire,
    input  logic                     merge_any,
    input  logic [PW-1:0]            merge_idx,
    input  logic [PW-1:0]            tail,
    input  logic [TW-1:0]            wtag,
    input  logic [WIDX-1:0]          widx,
    input  logic [DW-1:0]            wdata,
    input  logic                     pop,
    input  logic [PW-1:0]            head,
    output logic [ENTRIES-1:0]       occ,
    output logic [ENTRIES*TW-1:0]    tags_flat,
    output logic [ENTRIES*WORDS-1:0] masks_flat,
    output logic [ENTRIES*WORDS*DW-1:0] lines_flat
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        logic                occ_q;
        logic [TW-1:0]       tag_q;
        logic [WORDS-1:0]    mask_q;
        logic [WORDS*DW-1:0] line_q;
        logic                sel_new;
        logic                sel_mrg;
        logic                rel;

        assign sel_new = wr_fire && !merge_any && (tail == PW'(i));
        assign sel_mrg = wr_fire &&  merge_any && (merge_idx == PW'(i));
        assign rel     = pop && (head == PW'(i));

        // Entry update: release on drain, fresh fill on allocate, word write on merge.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                occ_q  <= 1'b0;
                tag_q  <= '0;
                mask_q <= '0;
                line_q <= '0;
            end else begin
                if (rel) begin
                    occ_q  <= 1'b0;
                    mask_q <= '0;
                end
                if (sel_new) begin
                    occ_q                  <= 1'b1;
                    tag_q                  <= wtag;
                    mask_q                 <= '0;
                    mask_q[widx]           <= 1'b1;
                    line_q[widx*DW +: DW]  <= wdata;
                end else if (sel_mrg) begin
                    mask_q[widx]           <= 1'b1;
                    line_q[widx*DW +: DW]  <= wdata;
                end
            end
        end

        assign occ[i]                          = occ_q;
        assign tags_flat[i*TW +: TW]           = tag_q;
        assign masks_flat[i*WORDS +: WORDS]    = mask_q;
        assign lines_flat[i*WORDS*DW +: WORDS*DW] = line_q;
    end
endmodule

// File: rtl/wbm_drain_ctl.sv
// Queue pointers, fill count and the drain decision for the head entry.
// Assumes alloc is never raised while the queue is full and pop only
// follows an offered head. The idle counter saturates at HOLD.
module wbm_drain_ctl #(
    parameter int ENTRIES = 4,
    parameter int HOLD    = 4,
    localparam int PW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int CW     = $clog2(ENTRIES + 1),
    localparam int IW     = $clog2(HOLD + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc,
    input  logic          wr_fire,
    input  logic          head_full,
    input  logic          mem_ready,
    output logic [PW-1:0] head,
    output logic [PW-1:0] tail,
    output logic          full,
    output logic          mem_valid,
    output logic          pop
);
    import wbm_pkg::*;

    head_state_e   st_q;
    logic [PW-1:0] head_q;
    logic [PW-1:0] tail_q;
    logic [CW-1:0] cnt_q;
    logic [IW-1:0] idle_q;
    logic          start;

    // Drain trigger: full head, a queued follower, or enough quiet cycles.
    assign start = (cnt_q != '0) &&
                   ((cnt_q > CW'(1)) || head_full || (idle_q >= IW'(HOLD)));

    assign mem_valid = (cnt_q != '0) && ((st_q == HD_SEND) || start);
    assign pop       = mem_valid && mem_ready;
    assign full      = (cnt_q == CW'(ENTRIES));
    assign head      = head_q;
    assign tail      = tail_q;

    // Head phase: latch the offer until memory accepts it.
    always_ff @(posedge clk) begin
        if (!rst_n)                     st_q <= HD_GATHER;
        else if (pop)                   st_q <= HD_GATHER;
        else if (mem_valid)             st_q <= HD_SEND;
    end

    // Ring pointers advance on release and on allocation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (pop)
                head_q <= (head_q == PW'(ENTRIES - 1)) ? '0 : head_q + PW'(1);
            if (alloc)
                tail_q <= (tail_q == PW'(ENTRIES - 1)) ? '0 : tail_q + PW'(1);
        end
    end

    // Occupancy count tracks allocations minus releases.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (alloc && !pop)  cnt_q <= cnt_q + CW'(1);
        else if (pop && !alloc)  cnt_q <= cnt_q - CW'(1);
    end

    // Quiet-cycle counter since the last accepted store.
    always_ff @(posedge clk) begin
        if (!rst_n)                      idle_q <= '0;
        else if (wr_fire)                idle_q <= '0;
        else if (idle_q < IW'(HOLD))     idle_q <= idle_q + IW'(1);
    end
endmodule

// File: rtl/merge_wbuf.sv
// Merging write buffer between a write-through cache and memory.
// Stores to one aligned block gather in one entry with per-word valid bits;
// entries drain in allocation order; read misses probe the buffered blocks.
// Assumes WORDS is a power of two of at least 2 and addresses are word addresses.
module merge_wbuf #(
    parameter int ENTRIES = 4,
    parameter int WORDS   = 4,
    parameter int DW      = 32,
    parameter int AW      = 30,
    parameter int HOLD    = 4,
    localparam int WIDX   = $clog2(WORDS),
    localparam int TW     = AW - WIDX,
    localparam int PW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_wr_valid,
    input  logic [AW-1:0]       cpu_wr_addr,
    input  logic [DW-1:0]       cpu_wr_data,
    output logic                cpu_wr_stall,
    input  logic [TW-1:0]       rd_chk_blk,
    output logic                rd_conflict,
    output logic                mem_wr_valid,
    input  logic                mem_wr_ready,
    output logic [TW-1:0]       mem_wr_blk,
    output logic [WORDS-1:0]    mem_wr_mask,
    output logic [WORDS*DW-1:0] mem_wr_data
);
    logic [ENTRIES-1:0]          occ_vec;
    logic [ENTRIES*TW-1:0]       tags_flat;
    logic [ENTRIES*WORDS-1:0]    masks_flat;
    logic [ENTRIES*WORDS*DW-1:0] lines_flat;
    logic [ENTRIES-1:0]          send_excl;
    logic [ENTRIES-1:0]          wr_hit;
    logic [ENTRIES-1:0]          rd_hit;
    logic                        merge_any;
    logic [PW-1:0]               merge_idx;
    logic [PW-1:0]               head_idx;
    logic [PW-1:0]               tail_idx;
    logic                        buf_full;
    logic                        pop;
    logic                        wr_fire;
    logic                        head_full;
    logic [TW-1:0]               wr_tag;
    logic [WIDX-1:0]             wr_word;

    assign wr_tag  = cpu_wr_addr[AW-1:WIDX];
    assign wr_word = cpu_wr_addr[WIDX-1:0];

    // The offered head entry is closed to merges.
    assign send_excl = mem_wr_valid ? (ENTRIES'(1) << head_idx) : '0;

    wbm_tag_match #(.ENTRIES(ENTRIES), .TW(TW)) u_wr_match (
        .occ       (occ_vec),
        .excl      (send_excl),
        .tags_flat (tags_flat),
        .probe     (wr_tag),
        .hit       (wr_hit)
    );

    wbm_tag_match #(.ENTRIES(ENTRIES), .TW(TW)) u_rd_match (
        .occ       (occ_vec),
        .excl      ('0),
        .tags_flat (tags_flat),
        .probe     (rd_chk_blk),
        .hit       (rd_hit)
    );

    wbm_prio #(.N(ENTRIES)) u_merge_pick (
        .req (wr_hit),
        .any (merge_any),
        .idx (merge_idx)
    );

    assign cpu_wr_stall = cpu_wr_valid && !merge_any && buf_full;
    assign wr_fire      = cpu_wr_valid && !cpu_wr_stall;
    assign rd_conflict  = |rd_hit;

    wbm_entry_store #(
        .ENTRIES(ENTRIES), .WORDS(WORDS), .DW(DW), .TW(TW)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_fire    (wr_fire),
        .merge_any  (merge_any),
        .merge_idx  (merge_idx),
        .tail       (tail_idx),
        .wtag       (wr_tag),
        .widx       (wr_word),
        .wdata      (cpu_wr_data),
        .pop        (pop),
        .head       (head_idx),
        .occ        (occ_vec),
        .tags_flat  (tags_flat),
        .masks_flat (masks_flat),
        .lines_flat (lines_flat)
    );

    assign mem_wr_blk  = tags_flat[head_idx*TW +: TW];
    assign mem_wr_mask = masks_flat[head_idx*WORDS +: WORDS];
    assign mem_wr_data = lines_flat[head_idx*WORDS*DW +: WORDS*DW];
    assign head_full   = &mem_wr_mask;

    wbm_drain_ctl #(.ENTRIES(ENTRIES), .HOLD(HOLD)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc     (wr_fire && !merge_any),
        .wr_fire   (wr_fire),
        .head_full (head_full),
        .mem_ready (mem_wr_ready),
        .head      (head_idx),
        .tail      (tail_idx),
        .full      (buf_full),
        .mem_valid (mem_wr_valid),
        .pop       (pop)
    );
endmodule

// Property checker for merge_wbuf, attached through bind below.
// Assumes occupancy and head index are taken from the buffer's internals.
module merge_wbuf_chk #(
    parameter int ENTRIES = 4,
    parameter int WORDS   = 4,
    parameter int DW      = 32,
    parameter int TW      = 28,
    localparam int PW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cpu_wr_stall,
    input logic                rd_conflict,
    input logic                mem_wr_valid,
    input logic                mem_wr_ready,
    input logic [TW-1:0]       mem_wr_blk,
    input logic [WORDS-1:0]    mem_wr_mask,
    input logic [WORDS*DW-1:0] mem_wr_data,
    input logic [ENTRIES-1:0]  occ,
    input logic [PW-1:0]       head
);
    a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (occ == '0) && !mem_wr_valid);

    a_r4_stall_only_full: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr_stall |-> (&occ));

    a_r6_offer_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid && !mem_wr_ready |=> mem_wr_valid);

    a_r6_payload_stable: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid && !mem_wr_ready |=>
            $stable(mem_wr_blk) && $stable(mem_wr_mask) && $stable(mem_wr_data));

    a_r5_offer_is_live: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> occ[head] && (mem_wr_mask != '0));

    a_r8_empty_no_conflict: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0) |-> !rd_conflict);
endmodule

bind merge_wbuf merge_wbuf_chk #(
    .ENTRIES(ENTRIES), .WORDS(WORDS), .DW(DW), .TW(TW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_wr_stall (cpu_wr_stall),
    .rd_conflict  (rd_conflict),
    .mem_wr_valid (mem_wr_valid),
    .mem_wr_ready (mem_wr_ready),
    .mem_wr_blk   (mem_wr_blk),
    .mem_wr_mask  (mem_wr_mask),
    .mem_wr_data  (mem_wr_data),
    .occ          (occ_vec),
    .head         (head_idx)
);

// File: tb/merge_wbuf_test.sv
// Directed and swept bench for merge_wbuf with default parameters.
module merge_wbuf_test;
    localparam int CLK_PERIOD = 10;
    localparam int W    = 4;
    localparam int DW   = 32;
    localparam int AW   = 30;
    localparam int TW   = AW - 2;
    localparam int HOLD = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_wr_valid = 1'b0;
    logic [AW-1:0]     cpu_wr_addr = '0;
    logic [DW-1:0]     cpu_wr_data = '0;
    logic              cpu_wr_stall;
    logic [TW-1:0]     rd_chk_blk = '0;
    logic              rd_conflict;
    logic              mem_wr_valid;
    logic              mem_wr_ready = 1'b0;
    logic [TW-1:0]     mem_wr_blk;
    logic [W-1:0]      mem_wr_mask;
    logic [W*DW-1:0]   mem_wr_data;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    merge_wbuf uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_wr_valid(cpu_wr_valid), .cpu_wr_addr(cpu_wr_addr),
        .cpu_wr_data(cpu_wr_data), .cpu_wr_stall(cpu_wr_stall),
        .rd_chk_blk(rd_chk_blk), .rd_conflict(rd_conflict),
        .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
        .mem_wr_blk(mem_wr_blk), .mem_wr_mask(mem_wr_mask),
        .mem_wr_data(mem_wr_data)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One store; expects it to be accepted (R4: no stall unless full).
    task automatic wr(input logic [TW-1:0] blk, input int w, input logic [DW-1:0] d);
        cpu_wr_valid = 1'b1;
        cpu_wr_addr  = {blk, 2'(w)};
        cpu_wr_data  = d;
        #1 chk("R4 accept", cpu_wr_stall, 1'b0);
        @(posedge clk);
        @(negedge clk);
        cpu_wr_valid = 1'b0;
    endtask

    // Offers a store and checks the stall level without a clock edge.
    task automatic probe_stall(input logic [TW-1:0] blk, input int w, input logic exp);
        cpu_wr_valid = 1'b1;
        cpu_wr_addr  = {blk, 2'(w)};
        cpu_wr_data  = 32'hDEAD_BEEF;
        #1 chk("R4 stall", cpu_wr_stall, exp);
        cpu_wr_valid = 1'b0;
        #1;
    endtask

    task automatic conflict(input logic [TW-1:0] blk, input logic exp, input string req);
        rd_chk_blk = blk;
        #1 chk(req, rd_conflict, exp);
    endtask

    // Waits for an offer, checks it, then lets memory take it.
    task automatic drain(input logic [TW-1:0] blk, input logic [W-1:0] m,
                         input logic [W*DW-1:0] d, input string req);
        logic [W*DW-1:0] bits;
        for (int k = 0; k < 20 && !mem_wr_valid; k++) @(negedge clk);
        bits = '0;
        for (int i = 0; i < W; i++) if (m[i]) bits[i*DW +: DW] = '1;
        chk({req, " valid"}, mem_wr_valid, 1'b1);
        chk({req, " blk"}, mem_wr_blk, blk);
        chk({req, " mask"}, mem_wr_mask, m);
        chk({req, " data"}, mem_wr_data & bits, d & bits);
        mem_wr_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        mem_wr_ready = 1'b0;
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [W*DW-1:0] line;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        chk("R1 stall", cpu_wr_stall, 1'b0);
        chk("R1 valid", mem_wr_valid, 1'b0);
        conflict(28'h40, 1'b0, "R1 conflict");

        // R2/R6: four sequential words merge into one entry; full head drains at once.
        for (int w = 0; w < 3; w++) wr(28'h40, w, 32'h1000 + w);
        chk("R6 not yet offered", mem_wr_valid, 1'b0);
        wr(28'h40, 3, 32'h1003);
        chk("R6 full head offered", mem_wr_valid, 1'b1);
        conflict(28'h40, 1'b1, "R8 buffered block");
        conflict(28'h80, 1'b0, "R8 other block");
        drain(28'h40, 4'b1111, {32'h1003, 32'h1002, 32'h1001, 32'h1000}, "R2 merged");
        chk("R5 released", mem_wr_valid, 1'b0);
        conflict(28'h40, 1'b0, "R8 after drain");

        // R3/R6: overwrite in place; idle drain after HOLD edges.
        wr(28'h55, 0, 32'hAAAA_0001);
        wr(28'h55, 0, 32'hAAAA_0002);
        repeat (HOLD - 1) @(negedge clk);
        chk("R6 hold not expired", mem_wr_valid, 1'b0);
        @(negedge clk);
        chk("R6 hold expired", mem_wr_valid, 1'b1);
        drain(28'h55, 4'b0001, {96'h0, 32'hAAAA_0002}, "R3 overwrite");
        chk("R3 single entry", mem_wr_valid, 1'b0);

        // R4/R5: fill, merge while full, stall, then FIFO drain.
        wr(28'h101, 0, 32'hB1);
        wr(28'h102, 0, 32'hB2);
        wr(28'h103, 0, 32'hB3);
        wr(28'h104, 0, 32'hB4);
        probe_stall(28'h102, 1, 1'b0);
        wr(28'h102, 1, 32'hB22);
        probe_stall(28'h105, 0, 1'b1);
        probe_stall(28'h101, 1, 1'b1);   // R7: head is offered, cannot merge
        drain(28'h101, 4'b0001, {96'h0, 32'hB1}, "R5 order 0");
        drain(28'h102, 4'b0011, {64'h0, 32'hB22, 32'hB2}, "R5 order 1");
        drain(28'h103, 4'b0001, {96'h0, 32'hB3}, "R5 order 2");
        drain(28'h104, 4'b0001, {96'h0, 32'hB4}, "R5 order 3");
        chk("R5 empty", mem_wr_valid, 1'b0);

        // R7: store to an offered head allocates a new entry.
        wr(28'h66, 2, 32'hC2);
        repeat (HOLD) @(negedge clk);
        chk("R7 head offered", mem_wr_valid, 1'b1);
        wr(28'h66, 3, 32'hC3);
        drain(28'h66, 4'b0100, {32'h0, 32'hC2, 64'h0}, "R7 first");
        conflict(28'h66, 1'b1, "R8 second copy buffered");
        drain(28'h66, 4'b1000, {32'hC3, 96'h0}, "R7 second");
        conflict(28'h66, 1'b0, "R8 all copies drained");

        // R2/R5 sweep: every non-empty word mask of one block.
        for (int m = 1; m < 16; m++) begin
            line = '0;
            for (int w = 0; w < W; w++) begin
                if (m[w]) begin
                    wr(28'h200 + 28'(m), w, 32'hA000_0000 | (m << 8) | w);
                    line[w*DW +: DW] = 32'hA000_0000 | (m << 8) | w;
                end
            end
            drain(28'h200 + 28'(m), 4'(m), line, "R2 sweep");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule